// File: doc/BRIEF.md
# UART Receive Flow-Control Character Detector

This block sits between a UART receiver and its receive FIFO. Each received character arrives as a one-cycle strobe with data. The block compares it against four programmable control characters: two resume codes and two stop codes. Characters that complete a stop sequence pause the local transmitter. While the transmitter is paused, characters that complete a resume sequence release it. Control characters used up this way never reach the FIFO. Every other character is passed to the FIFO write port in arrival order.

A sequence is either one character or two consecutive characters, chosen by a configuration bit. The comparison covers only the active word length of 5 to 8 bits. A separate special-character mode flags any received character equal to the second stop code and still stores that character. A sticky flag, with an interrupt gated by an enable bit, reports stop matches and special-character hits.

The receiver delivers at most one strobe in any two consecutive cycles. This always holds for a serial receiver, whose characters are many cycles apart.

Top module: `uart_xonxoff_detect`

## Requirements
- R1: After reset, all four control-character registers hold zero. With flow control on, a received 0x00 therefore matches the first stop code and pauses the transmitter.
- R2: In single mode, with flow control on and not paused, a character equal to the first stop code (register select 2) is consumed and pauses the transmitter.
- R3: In double mode, the first stop code followed directly by the second stop code (select 3) pauses the transmitter. Neither character is written to the FIFO.
- R4: In double mode, if the character after a pending first-code match does not complete the pair, the held character is written to the FIFO first. The new character is then judged as a possible first code; if it is not one, it is written one cycle later.
- R5: `tx_hold` rises only on a clock edge where `tx_busy` is low. Once high, it stays high until the transmitter is resumed.
- R6: While paused, only the resume codes are compared: the first resume code (select 0) alone, or followed by the second resume code (select 1) in double mode. A match resumes the transmitter, clears `flag` and is consumed. All other characters, stop codes included, are written.
- R7: A character that is not consumed is written unmodified, all 8 bits, through `fifo_we` and `fifo_data` on the edge that samples its strobe. The only exception is a deferred character under R4.
- R8: `flag` is set by a pause event or a special-character hit. It is cleared by `status_rd` or by a resume; a set in the same cycle as a clear wins. `irq` equals `flag` AND `cfg_irq_en`.
- R9: With `cfg_spec_en` set, a character equal to the second stop code sets `flag` and is always written to the FIFO. It is never consumed, and if a first code is pending it breaks the pair.
- R10: `cfg_wlen` values 0, 1, 2 and 3 select 5, 6, 7 and 8 compared bits. The comparison is aligned at bit 0, and upper bits are ignored.
- R11: With `cfg_fc_en` low, every character is written and the transmitter is never paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | 8 | Received character |
| reg_we | input | 1 | Control-character register write |
| reg_sel | input | 2 | Register select: 0 resume1, 1 resume2, 2 stop1, 3 stop2 |
| reg_wdata | input | 8 | Register write data |
| cfg_wlen | input | 2 | Word length: 0..3 gives 5..8 bits |
| cfg_fc_en | input | 1 | Software flow control enable |
| cfg_double | input | 1 | Two-character sequences |
| cfg_spec_en | input | 1 | Special-character detect enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| status_rd | input | 1 | Status read strobe, clears flag |
| tx_busy | input | 1 | Transmitter is mid-character |
| fifo_we | output | 1 | Receive FIFO write enable |
| fifo_data | output | 8 | Receive FIFO write data |
| tx_hold | output | 1 | Pause request to the transmitter |
| flag | output | 1 | Sticky stop or special-character flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a broken pair in double mode: a first code is held back, and the next character must both release it and be judged again. The bench drives 0x13 followed by an ordinary byte, and 0x13, 0x13, 0x93. It then checks the exact order of FIFO writes, including the deferred one. A second hard case is a stop match while the transmitter is busy. The bench holds `tx_busy` high across the match and checks that `tx_hold` waits for it to drop.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int CHAR_W = 8;
  localparam int NCODE  = 4;
  localparam int SEL_W  = $clog2(NCODE);

  typedef enum logic [SEL_W-1:0] {
    SEL_XON1  = 2'd0,
    SEL_XON2  = 2'd1,
    SEL_XOFF1 = 2'd2,
    SEL_XOFF2 = 2'd3
  } fc_sel_e;
endpackage

// File: rtl/fc_char_regs.sv
module fc_char_regs #(
  parameter int DW    = 8,
  parameter int NREG  = 4,
  localparam int SW   = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [SW-1:0]            sel,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  codes
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) codes[i] <= '0;
      else if (we && sel == SW'(i)) codes[i] <= wdata;
    end
  end
endmodule

// File: rtl/fc_cmp.sv
module fc_cmp #(
  parameter int DW   = 8,
  parameter int NREG = 4
) (
  input  logic [NREG-1:0][DW-1:0] codes,
  input  logic [DW-1:0]           data,
  input  logic [1:0]              wlen,
  output logic [NREG-1:0]         hit
);
  logic [DW-1:0] msk;
  logic [1:0]    drop;

  always_comb begin
    drop = 2'd3 - wlen;
    msk  = {DW{1'b1}} >> drop;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    assign hit[i] = ((codes[i] ^ data) & msk) == '0;
  end
endmodule

// File: rtl/fc_seq.sv
module fc_seq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic [3:0]    hit,
  input  logic          fc_en,
  input  logic          dbl,
  input  logic          spec_en,
  output logic          fifo_we,
  output logic [DW-1:0] fifo_data,
  output logic          paused,
  output logic          paused_nx,
  output logic          pause_ev,
  output logic          resume_ev,
  output logic          spec_ev
);
  import uart_fc_pkg::*;

  logic          pend_q, pend_n;
  logic [DW-1:0] held_q, held_n;
  logic          defv_q, defv_n;
  logic [DW-1:0] defd_q, defd_n;
  logic          we_n;
  logic [DW-1:0] wd_n;
  logic          spec_hit, first_hit, second_hit, allow;

  always_comb begin
    we_n       = 1'b0;
    wd_n       = fifo_data;
    defv_n     = 1'b0;
    defd_n     = defd_q;
    pend_n     = pend_q;
    held_n     = held_q;
    paused_nx  = paused;
    pause_ev   = 1'b0;
    resume_ev  = 1'b0;
    spec_hit   = spec_en & hit[SEL_XOFF2];
    first_hit  = paused ? hit[SEL_XON1] : hit[SEL_XOFF1];
    second_hit = paused ? hit[SEL_XON2] : hit[SEL_XOFF2];
    allow      = fc_en & ~spec_hit;
    spec_ev    = rx_valid & spec_hit;

    if (defv_q) begin
      we_n = 1'b1;
      wd_n = defd_q;
    end

    if (rx_valid) begin
      if (pend_q) begin
        pend_n = 1'b0;
        if (allow && second_hit) begin
          paused_nx = ~paused;
          pause_ev  = ~paused;
          resume_ev = paused;
        end else begin
          we_n = 1'b1;
          wd_n = held_q;
          if (allow && first_hit) begin
            pend_n = 1'b1;
            held_n = rx_data;
          end else begin
            defv_n = 1'b1;
            defd_n = rx_data;
          end
        end
      end else if (allow && first_hit) begin
        if (dbl) begin
          pend_n = 1'b1;
          held_n = rx_data;
        end else begin
          paused_nx = ~paused;
          pause_ev  = ~paused;
          resume_ev = paused;
        end
      end else begin
        we_n = 1'b1;
        wd_n = rx_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      held_q    <= '0;
      defv_q    <= 1'b0;
      defd_q    <= '0;
      fifo_we   <= 1'b0;
      fifo_data <= '0;
      paused    <= 1'b0;
    end else begin
      pend_q    <= pend_n;
      held_q    <= held_n;
      defv_q    <= defv_n;
      defd_q    <= defd_n;
      fifo_we   <= we_n;
      fifo_data <= wd_n;
      paused    <= paused_nx;
    end
  end
endmodule

// File: rtl/uart_xonxoff_detect.sv
module uart_xonxoff_detect #(
  parameter int DW = uart_fc_pkg::CHAR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic [1:0]    cfg_wlen,
  input  logic          cfg_fc_en,
  input  logic          cfg_double,
  input  logic          cfg_spec_en,
  input  logic          cfg_irq_en,
  input  logic          status_rd,
  input  logic          tx_busy,
  output logic          fifo_we,
  output logic [DW-1:0] fifo_data,
  output logic          tx_hold,
  output logic          flag,
  output logic          irq
);
  import uart_fc_pkg::*;

  logic [NCODE-1:0][DW-1:0] codes;
  logic [NCODE-1:0]         hit;
  logic paused, paused_nx, pause_ev, resume_ev, spec_ev;
  logic flag_n, hold_n;

  fc_char_regs #(.DW(DW), .NREG(NCODE)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel),
    .wdata(reg_wdata), .codes(codes)
  );

  fc_cmp #(.DW(DW), .NREG(NCODE)) u_cmp (
    .codes(codes), .data(rx_data), .wlen(cfg_wlen), .hit(hit)
  );

  fc_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .hit(hit), .fc_en(cfg_fc_en), .dbl(cfg_double), .spec_en(cfg_spec_en),
    .fifo_we(fifo_we), .fifo_data(fifo_data), .paused(paused),
    .paused_nx(paused_nx), .pause_ev(pause_ev), .resume_ev(resume_ev),
    .spec_ev(spec_ev)
  );

  always_comb begin
    flag_n = flag;
    if (status_rd || resume_ev) flag_n = 1'b0;
    if (pause_ev || spec_ev)    flag_n = 1'b1;
    if (!paused_nx)             hold_n = 1'b0;
    else                        hold_n = tx_hold | ~tx_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      irq     <= 1'b0;
      tx_hold <= 1'b0;
    end else begin
      flag    <= flag_n;
      irq     <= flag_n & cfg_irq_en;
      tx_hold <= hold_n;
    end
  end

  logic unused_paused;
  assign unused_paused = paused;
endmodule

// File: rtl/uart_xonxoff_detect_chk.sv
module uart_xonxoff_detect_chk (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic tx_busy,
  input logic fifo_we,
  input logic tx_hold,
  input logic flag,
  input logic irq
);
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_hold) |-> !$past(tx_busy));

  p_hold_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_hold && !rx_valid) |=> tx_hold);

  p_irq_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);

  p_write_source_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_we) |-> $past(rx_valid));

  p_resume_clears_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_hold) |-> !flag);

  p_rx_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

bind uart_xonxoff_detect uart_xonxoff_detect_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .tx_busy(tx_busy),
  .fifo_we(fifo_we), .tx_hold(tx_hold), .flag(flag), .irq(irq)
);

// File: tb/sim_uart_xonxoff_detect.sv
`timescale 1ns/1ps
module sim_uart_xonxoff_detect;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_fc_en = 1'b0, cfg_double = 1'b0, cfg_spec_en = 1'b0, cfg_irq_en = 1'b0;
  logic       status_rd = 1'b0, tx_busy = 1'b0;
  logic       fifo_we, tx_hold, flag, irq;
  logic [7:0] fifo_data;

  int checks = 0, failures = 0;
  logic [7:0] cap [0:63];
  int ncap = 0;

  always #4 clk = ~clk;

  uart_xonxoff_detect u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cfg_wlen(cfg_wlen), .cfg_fc_en(cfg_fc_en), .cfg_double(cfg_double),
    .cfg_spec_en(cfg_spec_en), .cfg_irq_en(cfg_irq_en), .status_rd(status_rd),
    .tx_busy(tx_busy), .fifo_we(fifo_we), .fifo_data(fifo_data),
    .tx_hold(tx_hold), .flag(flag), .irq(irq)
  );

  always @(negedge clk) begin
    if (!rst && fifo_we && ncap < 64) begin
      cap[ncap] = fifo_data;
      ncap++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cfg_fc_en = 0; cfg_double = 0; cfg_spec_en = 0; cfg_irq_en = 0;
    cfg_wlen = 2'd3; tx_busy = 0; status_rd = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    ncap = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1; rx_data = d;
    @(negedge clk);
    rx_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_status();
    @(negedge clk);
    status_rd = 1;
    @(negedge clk);
    status_rd = 0;
  endtask

  task automatic setup_codes();
    wr(2'd0, 8'h11); wr(2'd1, 8'h91); wr(2'd2, 8'h13); wr(2'd3, 8'h93);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset tx_hold", tx_hold, 0);
    check("R1 reset flag", flag, 0);
    check("R1 reset irq", irq, 0);
    check("R1 reset fifo_we", fifo_we, 0);
    cfg_fc_en = 1;
    send(8'h00);
    check("R1 zero code pauses", tx_hold, 1);
    check("R1 zero code consumed", ncap, 0);
  endtask

  task automatic t_passthru();
    do_reset();
    setup_codes();
    send(8'h13); send(8'h55);
    check("R11 count", ncap, 2);
    check("R11 first", cap[0], 8'h13);
    check("R11 second", cap[1], 8'h55);
    check("R11 no pause", tx_hold, 0);
  endtask

  task automatic t_single();
    do_reset();
    setup_codes();
    cfg_fc_en = 1; cfg_irq_en = 1;
    send(8'h41); send(8'h13);
    check("R2 data written", ncap, 1);
    check("R7 data unmodified", cap[0], 8'h41);
    check("R2 paused", tx_hold, 1);
    check("R8 flag on pause", flag, 1);
    check("R8 irq on pause", irq, 1);
    send(8'h42); send(8'h13);
    check("R6 others written while paused", ncap, 3);
    check("R6 stop code written while paused", cap[2], 8'h13);
    check("R6 still paused", tx_hold, 1);
    send(8'h11);
    check("R6 resume", tx_hold, 0);
    check("R6 flag cleared", flag, 0);
    check("R6 resume consumed", ncap, 3);
  endtask

  task automatic t_busy();
    do_reset();
    setup_codes();
    cfg_fc_en = 1;
    tx_busy = 1;
    send(8'h13);
    check("R5 held off while busy", tx_hold, 0);
    check("R8 flag while busy", flag, 1);
    repeat (3) @(negedge clk);
    check("R5 still waiting", tx_hold, 0);
    tx_busy = 0;
    @(negedge clk);
    check("R5 rises when idle", tx_hold, 1);
    tx_busy = 1;
    repeat (2) @(negedge clk);
    check("R5 sticky", tx_hold, 1);
    send(8'h11);
    check("R5 released on resume", tx_hold, 0);
    tx_busy = 0;
  endtask

  task automatic t_status();
    do_reset();
    setup_codes();
    cfg_fc_en = 1; cfg_irq_en = 1;
    send(8'h13);
    rd_status();
    check("R8 read clears flag", flag, 0);
    check("R8 read clears irq", irq, 0);
    check("R8 read keeps pause", tx_hold, 1);
    send(8'h11);
    cfg_irq_en = 0;
    send(8'h13);
    check("R8 flag without irq", flag, 1);
    check("R8 irq gated", irq, 0);
    send(8'h11);
  endtask

  task automatic t_double();
    do_reset();
    setup_codes();
    cfg_fc_en = 1; cfg_double = 1;
    send(8'h13);
    check("R3 half pair no pause", tx_hold, 0);
    check("R3 half pair held", ncap, 0);
    send(8'h93);
    check("R3 pair pauses", tx_hold, 1);
    check("R3 pair consumed", ncap, 0);
    send(8'h11);
    check("R6 half resume pair", tx_hold, 1);
    send(8'h91);
    check("R6 pair resumes", tx_hold, 0);
    check("R6 pair consumed", ncap, 0);
  endtask

  task automatic t_mismatch();
    do_reset();
    setup_codes();
    cfg_fc_en = 1; cfg_double = 1;
    send(8'h13); send(8'h41);
    check("R4 both written", ncap, 2);
    check("R4 held first", cap[0], 8'h13);
    check("R4 deferred second", cap[1], 8'h41);
    check("R4 no pause", tx_hold, 0);
    send(8'h13); send(8'h13); send(8'h93);
    check("R4 one released", ncap, 3);
    check("R4 released value", cap[2], 8'h13);
    check("R4 rejudged pair pauses", tx_hold, 1);
  endtask

  task automatic t_width();
    do_reset();
    setup_codes();
    cfg_fc_en = 1; cfg_wlen = 2'd0;
    send(8'hF3);
    check("R10 5-bit match pauses", tx_hold, 1);
    send(8'h31);
    check("R10 5-bit resume", tx_hold, 0);
    cfg_wlen = 2'd3;
    send(8'hF3);
    check("R10 8-bit no match", tx_hold, 0);
    check("R10 8-bit written", ncap, 1);
    cfg_wlen = 2'd2;
    send(8'h93);
    check("R10 7-bit match pauses", tx_hold, 1);
    send(8'h11);
  endtask

  task automatic t_special();
    do_reset();
    wr(2'd2, 8'h13); wr(2'd3, 8'h7E);
    cfg_spec_en = 1; cfg_irq_en = 1;
    send(8'h7E);
    check("R9 special written", ncap, 1);
    check("R9 special value", cap[0], 8'h7E);
    check("R9 special flag", flag, 1);
    check("R9 special irq", irq, 1);
    rd_status();
    send(8'h7D);
    check("R9 plain no flag", flag, 0);
    cfg_fc_en = 1; cfg_double = 1;
    ncap = 0;
    send(8'h13); send(8'h7E);
    check("R9 pair broken count", ncap, 2);
    check("R9 held first", cap[0], 8'h13);
    check("R9 special after", cap[1], 8'h7E);
    check("R9 no pause", tx_hold, 0);
    check("R9 flag in fc mode", flag, 1);
  endtask

  initial begin
    t_reset();
    t_passthru();
    t_single();
    t_busy();
    t_status();
    t_double();
    t_mismatch();
    t_width();
    t_special();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule